// File: doc/BRIEF.md
# GPIO Edge-Triggered NMI Capture

This block watches sixteen general-purpose input pins and records qualifying edges as sticky flags that together raise a non-maskable interrupt request. Each raw pin first passes through a two-stage synchronizer. A change is then detected by comparing the settled level with the level one cycle earlier. A per-pin polarity bit selects the edge that counts: a rising edge when the bit is clear, a falling edge when it is set. An edge is captured only when three conditions hold at once: the pin is configured as an input, its routing selects the NMI, and its enable flag is set.

Software uses a small register port with byte enables. It reads and writes an enable register at offset 0x28 and a status register at offset 0x2A. The status register is cleared by writing ones. Pins 0–7 live in the core reset domain and pins 8–15 in the resume domain, so each half of each register has its own reset. The logic is built as two identical 8-pin lanes. Lane 0 is reset by the core reset and lane 1 by the resume reset.

Top module: `gpi_nmi_detect`

## Requirements
- R1: After both resets, the enable register reads 0x0000, the status register reads 0x0000 and `nmi_req` is 0.
- R2: A write to offset 0x28 stores `reg_wdata` into the enable register. `reg_be[0]` gates bits 7:0 and `reg_be[1]` gates bits 15:8, and a read of 0x28 returns the stored value.
- R3: A write to offset 0x2A clears each status bit whose data bit is 1 and whose byte enable is set. Data bits of 0 leave their status bits unchanged.
- R4: A status bit never sets unless its pin has `pin_is_input`, `pin_route_nmi` and the enable bit all at 1.
- R5: When `pin_invert` is 0, a low-to-high change on a qualified pin sets its status bit, and a high-to-low change does not.
- R6: When `pin_invert` is 1, a high-to-low change on a qualified pin sets its status bit, and a low-to-high change does not.
- R7: A pin change driven between clock edges shows in the status register after the third following rising edge and not after the second.
- R8: If an edge event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: `nmi_req` is 1 exactly when some status bit has both its enable bit and its `pin_route_nmi` at 1. It stays at 1 until all such bits are cleared.
- R10: Asserting `rst_core_n` alone clears only bits 7:0 of both registers. Asserting `rst_resume_n` alone clears only bits 15:8.
- R11: A read of any offset other than 0x28 or 0x2A returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_core_n | input | 1 | Asynchronous active-low reset for pins 0–7 |
| rst_resume_n | input | 1 | Asynchronous active-low reset for pins 8–15 |
| pin_raw | input | 16 | Unsynchronized pin levels |
| pin_is_input | input | 16 | Pin configured as input |
| pin_route_nmi | input | 16 | Pin routing selects NMI |
| pin_invert | input | 16 | Polarity select: 0 rising, 1 falling |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 8 | Register offset |
| reg_be | input | 2 | Byte enables, bit 0 for the low byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| nmi_req | output | 1 | NMI request |

## Verification
The assertions assume that the configuration inputs and the register port are synchronous to `clk`. They also assume that only the pin levels may change at any time. The clear and set-wins properties are written per bit. They hold whether or not an edge event falls in the cycle of a write. The stimulus drives every input at the falling clock edge. It holds each random pin pattern for four cycles so the synchronizer settles before the reference model updates. It drops a pin low before an isolated reset so that no edge is left pending across the reset.

// File: rtl/gpi_nmi_pkg.sv
package gpi_nmi_pkg;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h2A;

    // Polarity-selected edge hits: rising where inv=0, falling where inv=1
    function automatic logic [LANE_W-1:0] edge_hits(
        input logic [LANE_W-1:0] prev,
        input logic [LANE_W-1:0] cur,
        input logic [LANE_W-1:0] inv
    );
        return (~inv & ~prev & cur) | (inv & prev & ~cur);
    endfunction
endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= raw;
            lvl_q  <= meta_q;
            prv_q  <= lvl_q;
        end
    end

    assign lvl = lvl_q;
    assign prv = prv_q;
endmodule

// File: rtl/gpi_lane.sv
module gpi_lane
    import gpi_nmi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] raw,
    input  logic [LANE_W-1:0] is_in,
    input  logic [LANE_W-1:0] route,
    input  logic [LANE_W-1:0] inv,
    input  logic              en_we,
    input  logic              sts_we,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] en_q,
    output logic [LANE_W-1:0] sts_q,
    output logic [LANE_W-1:0] evt
);
    logic [LANE_W-1:0] lvl;
    logic [LANE_W-1:0] prv;
    logic [LANE_W-1:0] clr;
    logic [LANE_W-1:0] en_r;
    logic [LANE_W-1:0] sts_r;

    gpi_sync #(.W(LANE_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw),
        .lvl  (lvl),
        .prv  (prv)
    );

    always_comb begin
        evt = edge_hits(prv, lvl, inv) & is_in & route & en_r;
        clr = sts_we ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_r  <= '0;
            sts_r <= '0;
        end else begin
            if (en_we) en_r <= wdata;
            sts_r <= (sts_r & ~clr) | evt;   // a new event outranks a clear
        end
    end

    assign en_q  = en_r;
    assign sts_q = sts_r;
endmodule

// File: rtl/gpi_nmi_detect.sv
module gpi_nmi_detect
    import gpi_nmi_pkg::*;
#(
    parameter int unsigned NPIN = 16
) (
    input  logic              clk,
    input  logic              rst_core_n,
    input  logic              rst_resume_n,
    input  logic [NPIN-1:0]   pin_raw,
    input  logic [NPIN-1:0]   pin_is_input,
    input  logic [NPIN-1:0]   pin_route_nmi,
    input  logic [NPIN-1:0]   pin_invert,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPIN/LANE_W-1:0] reg_be,
    input  logic [NPIN-1:0]   reg_wdata,
    output logic [NPIN-1:0]   reg_rdata,
    output logic              nmi_req
);
    localparam int unsigned NLANE = NPIN / LANE_W;

    logic [NPIN-1:0] en_q;
    logic [NPIN-1:0] sts_q;
    logic [NPIN-1:0] evt;
    logic            hit_en;
    logic            hit_sts;

    assign hit_en  = reg_wr && (reg_addr == OFS_ENABLE);
    assign hit_sts = reg_wr && (reg_addr == OFS_STATUS);

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic lane_rst_n;
        if (g == 0) begin : g_core
            assign lane_rst_n = rst_core_n;
        end else begin : g_resume
            assign lane_rst_n = rst_resume_n;
        end

        gpi_lane u_lane (
            .clk   (clk),
            .rst_n (lane_rst_n),
            .raw   (pin_raw[g*LANE_W +: LANE_W]),
            .is_in (pin_is_input[g*LANE_W +: LANE_W]),
            .route (pin_route_nmi[g*LANE_W +: LANE_W]),
            .inv   (pin_invert[g*LANE_W +: LANE_W]),
            .en_we (hit_en && reg_be[g]),
            .sts_we(hit_sts && reg_be[g]),
            .wdata (reg_wdata[g*LANE_W +: LANE_W]),
            .en_q  (en_q[g*LANE_W +: LANE_W]),
            .sts_q (sts_q[g*LANE_W +: LANE_W]),
            .evt   (evt[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        unique case (reg_addr)
            OFS_ENABLE: reg_rdata = en_q;
            OFS_STATUS: reg_rdata = sts_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign nmi_req = |(sts_q & en_q & pin_route_nmi);
endmodule

// File: rtl/gpi_nmi_detect_chk.sv
module gpi_nmi_detect_chk
    import gpi_nmi_pkg::*;
#(
    parameter int unsigned NPIN = 16
) (
    input logic                   clk,
    input logic                   rst_core_n,
    input logic                   rst_resume_n,
    input logic                   reg_wr,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [NPIN/LANE_W-1:0] reg_be,
    input logic [NPIN-1:0]        reg_wdata,
    input logic [NPIN-1:0]        pin_is_input,
    input logic [NPIN-1:0]        pin_route_nmi,
    input logic                   nmi_req,
    input logic [NPIN-1:0]        en_q,
    input logic [NPIN-1:0]        sts_q,
    input logic [NPIN-1:0]        evt
);
    for (genvar i = 0; i < NPIN; i++) begin : g_bit
        localparam int unsigned L = i / LANE_W;

        a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_resume_n)
            (reg_wr && reg_addr == OFS_STATUS && reg_be[L] && reg_wdata[i] && !evt[i]) |=> !sts_q[i]);

        a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_resume_n)
            (sts_q[i] && !(reg_wr && reg_addr == OFS_STATUS && reg_be[L] && reg_wdata[i])) |=> sts_q[i]);

        a_r4_qualified_set: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_resume_n)
            $rose(sts_q[i]) |-> $past(pin_is_input[i] && pin_route_nmi[i] && en_q[i]));

        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_resume_n)
            evt[i] |=> sts_q[i]);

        a_r2_enable_store: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_resume_n)
            (reg_wr && reg_addr == OFS_ENABLE && reg_be[L]) |=> (en_q[i] == $past(reg_wdata[i])));
    end

    a_r9_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_core_n || !rst_resume_n)
        (sts_q == '0) |-> !nmi_req);
endmodule

bind gpi_nmi_detect gpi_nmi_detect_chk #(.NPIN(NPIN)) u_chk (
    .clk          (clk),
    .rst_core_n   (rst_core_n),
    .rst_resume_n (rst_resume_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_be       (reg_be),
    .reg_wdata    (reg_wdata),
    .pin_is_input (pin_is_input),
    .pin_route_nmi(pin_route_nmi),
    .nmi_req      (nmi_req),
    .en_q         (en_q),
    .sts_q        (sts_q),
    .evt          (evt)
);

// File: tb/gpi_nmi_detect_test.sv
`timescale 1ns/1ps
module gpi_nmi_detect_test;
    logic        clk = 1'b0;
    logic        rst_core_n = 1'b0;
    logic        rst_resume_n = 1'b0;
    logic [15:0] pin_raw = '0;
    logic [15:0] pin_is_input = '0;
    logic [15:0] pin_route_nmi = '0;
    logic [15:0] pin_invert = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        nmi_req;

    int total = 0;
    int bad = 0;
    logic [15:0] m_en = '0;
    logic [15:0] m_sts = '0;
    logic [15:0] m_lvl = '0;

    localparam logic [7:0] A_EN  = 8'h28;
    localparam logic [7:0] A_STS = 8'h2A;

    always #5 clk = ~clk;

    gpi_nmi_detect uut (
        .clk(clk), .rst_core_n(rst_core_n), .rst_resume_n(rst_resume_n),
        .pin_raw(pin_raw), .pin_is_input(pin_is_input), .pin_route_nmi(pin_route_nmi),
        .pin_invert(pin_invert), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_req(nmi_req)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
        logic [15:0] mask;
        mask = {{8{be[1]}}, {8{be[0]}}};
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        if (a == A_EN)  m_en  = (m_en & ~mask) | (d & mask);
        if (a == A_STS) m_sts = m_sts & ~(d & mask);
    endtask

    function automatic logic [15:0] hits(input logic [15:0] o, input logic [15:0] n,
                                         input logic [15:0] inv, input logic [15:0] q);
        return q & ((~inv & ~o & n) | (inv & o & ~n));
    endfunction

    // drive a pin pattern and configuration, let it settle, update the model
    task automatic step(input logic [15:0] raw, input logic [15:0] isin,
                        input logic [15:0] rt, input logic [15:0] inv);
        @(negedge clk);
        pin_raw = raw; pin_is_input = isin; pin_route_nmi = rt; pin_invert = inv;
        repeat (4) @(posedge clk);
        m_sts = m_sts | hits(m_lvl, raw, inv, isin & rt & m_en);
        m_lvl = raw;
    endtask

    task automatic check_all(input string req);
        logic [15:0] d;
        rd(A_STS, d);
        check(req, d, m_sts);
        check({req, " nmi"}, {15'd0, nmi_req}, {15'd0, |(m_sts & m_en & pin_route_nmi)});
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_core_n = 1'b1; rst_resume_n = 1'b1;

        // R1: reset state
        rd(A_EN, d);  check("R1 enable", d, 16'h0000);
        rd(A_STS, d); check("R1 status", d, 16'h0000);
        check("R1 nmi", {15'd0, nmi_req}, 16'h0000);

        // R2: enable write and byte lanes; R11: other offsets
        wr(A_EN, 2'b11, 16'hFFFF);
        rd(A_EN, d); check("R2 full write", d, 16'hFFFF);
        wr(A_EN, 2'b01, 16'h0000);
        rd(A_EN, d); check("R2 low byte only", d, 16'hFF00);
        wr(A_EN, 2'b10, 16'h3C00);
        rd(A_EN, d); check("R2 high byte only", d, 16'h3C00);
        rd(8'h2C, d); check("R11 unmapped read", d, 16'h0000);
        wr(A_EN, 2'b11, 16'hFFFF);

        // R7: latency of an edge on pin 0
        @(negedge clk);
        pin_is_input = 16'hFFFF; pin_route_nmi = 16'hFFFF; pin_invert = 16'h0000;
        reg_addr = A_STS;
        pin_raw = 16'h0001;
        @(posedge clk); @(posedge clk);
        #1 check("R7 not after two edges", reg_rdata, 16'h0000);
        @(posedge clk);
        #1 check("R7 after three edges", reg_rdata, 16'h0001);
        m_sts = 16'h0001; m_lvl = 16'h0001;

        // R5 and R9: rising edges, falling edge ignored
        check("R9 nmi raised", {15'd0, nmi_req}, 16'h0001);
        step(16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000);
        check_all("R5 falling ignored");
        step(16'h0102, 16'hFFFF, 16'hFFFF, 16'h0000);
        check_all("R5 rising captured");

        // R3: write-one clears, write-zero keeps
        wr(A_STS, 2'b11, 16'h0000);
        check_all("R3 zero write keeps");
        wr(A_STS, 2'b01, 16'h0103);
        check_all("R3 low byte clear only");
        wr(A_STS, 2'b11, 16'hFFFF);
        check_all("R9 nmi drops when all clear");

        // R6: inverted polarity
        step(16'h00F0, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        check_all("R6 rising ignored");
        step(16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        check_all("R6 falling captured");
        wr(A_STS, 2'b11, 16'hFFFF);

        // R4: each qualifier missing in turn
        step(16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000);
        step(16'h0007, 16'hFFFE, 16'hFFFD, 16'h0000);
        wr(A_EN, 2'b11, 16'hFFFB);
        step(16'h0000, 16'hFFFE, 16'hFFFD, 16'h0000);
        step(16'h0007, 16'hFFFE, 16'hFFFD, 16'h0000);
        check_all("R4 unqualified pins stay clear");
        wr(A_EN, 2'b11, 16'hFFFF);
        wr(A_STS, 2'b11, 16'hFFFF);

        // R8: edge and clear collide on pin 0
        step(16'h0001, 16'hFFFF, 16'hFFFF, 16'h0000);
        step(16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000);
        @(negedge clk);
        pin_raw = 16'h0001;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STS; reg_be = 2'b11; reg_wdata = 16'h0001;
        @(posedge clk);
        #1 reg_wr = 1'b0;
        m_lvl = 16'h0001; m_sts = 16'h0001;
        check_all("R8 set wins over clear");
        wr(A_STS, 2'b11, 16'hFFFF);

        // random traffic: R3 R4 R5 R6 R9
        for (int k = 0; k < 300; k++) begin
            logic [15:0] rr, ii, ro, iv;
            rr = 16'($urandom); ii = 16'($urandom) | 16'($urandom);
            ro = 16'($urandom) | 16'($urandom); iv = 16'($urandom);
            step(rr, ii, ro, iv);
            if (($urandom % 4) == 0) wr(A_STS, 2'($urandom), 16'($urandom));
            if (($urandom % 8) == 0) wr(A_EN, 2'($urandom), 16'($urandom));
            check_all("R4 R5 R6 R3 R9 random");
        end

        // R10: split reset domains
        wr(A_EN, 2'b11, 16'hFFFF);
        step(16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000);
        step(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000);
        step(16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000);
        @(negedge clk); rst_core_n = 1'b0;
        @(negedge clk); rst_core_n = 1'b1;
        m_en = m_en & 16'hFF00; m_sts = m_sts & 16'hFF00;
        rd(A_EN, d);  check("R10 core reset enable", d, 16'hFF00);
        rd(A_STS, d); check("R10 core reset status", d, 16'hFF00);
        @(negedge clk); rst_resume_n = 1'b0;
        @(negedge clk); rst_resume_n = 1'b1;
        wr(A_EN, 2'b01, 16'h00AA);
        rd(A_EN, d);  check("R10 resume reset enable", d, 16'h00AA);
        rd(A_STS, d); check("R10 resume reset status", d, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule